// File: doc/BRIEF.md
# Cascadable Serial-Load LED Channel Front End

This block is the synchronous control logic that sits in front of a bank of LED sink drivers. A host writes channel patterns into it over three slow control pins: a serial data line, a shift clock and a latch strobe. A fourth pin, an active-low enable, blanks every channel at once. The block oversamples all four pins with a fast system clock, so every internal register runs on that one clock. A rising edge on the shift clock becomes a one-cycle shift pulse.

Each shift pulse moves one bit into a chain of per-channel stages, and the newest bit enters at channel 0. While the strobe is high, a level-sensitive holding stage copies the chain. While the strobe is low, the holding stage keeps its value. The enable then gates the held pattern onto the channel-on vector. The last stage of the chain drives a serial output, so several blocks can share one clock, strobe and enable, and the data passes from one block to the next.

The shift-clock edge is found by a two-state machine. In `SCLK_LOW`, a synchronized high level on the shift clock causes the transition `SCLK_LOW -> SCLK_HIGH` and raises the shift pulse for that cycle. In `SCLK_HIGH`, a synchronized low level causes the transition `SCLK_HIGH -> SCLK_LOW`, with no pulse. Each state holds when the level does not change.

Top module: `led_sink_front`

## Requirements
- R1: While reset is asserted, and until the first shift after it, every channel output and the serial output are 0. The enable synchronizer resets to the blanking level (1) and the strobe synchronizer resets to the hold level (0).
- R2: The chain advances exactly once for each rising edge of the shift clock pin, however long the pin stays high. A falling edge, or a steady level, leaves the chain unchanged.
- R3: After a shift, channel k holds the bit that was shifted in k shifts earlier. Bit 0 of the channel vector is the newest bit and bit CHANNELS-1 is the oldest.
- R4: The serial output always equals the chain stage of the highest channel (CHANNELS-1). A second block fed from it receives each bit CHANNELS shifts after it entered the first block.
- R5: While the synchronized strobe is high, the holding stage loads the chain contents on every system cycle, so the outputs follow the chain one cycle later.
- R6: While the synchronized strobe is low, the holding stage keeps its value, and further shifting does not change the channel outputs.
- R7: When enable_n is 1, all channel outputs are 0. When enable_n is 0, channel k is 1 exactly when its held bit is 1.
- R8: A change on enable_n reaches the channel outputs after exactly SYNC_STAGES system clock edges (two by default).
- R9: If a shift pulse and a high synchronized strobe fall in the same system cycle, the holding stage shows the pre-shift contents after that cycle and the post-shift contents one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data pin, taken on shift clock rising edges |
| shift_clk | input | 1 | Shift clock pin (asynchronous) |
| strobe | input | 1 | Latch strobe pin: 1 = transparent, 0 = hold |
| enable_n | input | 1 | Output enable pin, active low: 1 = all channels off |
| ser_out | output | 1 | Cascade output, equal to the last chain stage |
| chan_on | output | CHANNELS | Channel-on vector, bit k drives channel k |

## Verification
The bench builds two instances with the default CHANNELS=16 and SYNC_STAGES=2 and chains them through the serial output. One 32-bit stream therefore checks the channel ordering in both blocks and the cascade hand-off. With two synchronizer stages, the cases that depend on exact latency can be placed on a known cycle: enable taking effect on the second edge, and a strobe rising together with a shift-clock edge. A behavioural queue model of the pin delays and the chain is compared with both blocks on every clock. Directed checks then cover holding while the strobe is low, blanking, a long shift-clock high, and a falling shift-clock edge.

// File: rtl/led_front_pkg.sv
package led_front_pkg;

    // Shift-clock level tracker states
    typedef enum logic {
        SCLK_LOW  = 1'b0,
        SCLK_HIGH = 1'b1
    } sclk_state_e;

    // Positions of the control pins inside the synchronizer vector
    localparam int PIN_COUNT  = 4;
    localparam int PIN_SIN    = 0;
    localparam int PIN_SCLK   = 1;
    localparam int PIN_STROBE = 2;
    localparam int PIN_ENN    = 3;

endpackage

// File: rtl/led_pin_sync.sv
module led_pin_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= pin_async;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign pin_sync = stage_q[STAGES-1];

endmodule

// File: rtl/led_sclk_edge.sv
module led_sclk_edge
    import led_front_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    output logic shift_pulse
);

    sclk_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SCLK_LOW;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCLK_LOW:  if (sclk_s)  state_d = SCLK_HIGH;
            SCLK_HIGH: if (!sclk_s) state_d = SCLK_LOW;
            default:                state_d = SCLK_LOW;
        endcase
    end

    // Outputs
    always_comb begin
        shift_pulse = 1'b0;
        unique case (state_q)
            SCLK_LOW:  shift_pulse = sclk_s;
            SCLK_HIGH: shift_pulse = 1'b0;
            default:   shift_pulse = 1'b0;
        endcase
    end

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> !shift_pulse);

endmodule

// File: rtl/led_shift_chain.sv
module led_shift_chain #(
    parameter int STAGES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_pulse,
    input  logic              sin_s,
    output logic [STAGES-1:0] chain_q,
    output logic              ser_out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           chain_q <= '0;
        else if (shift_pulse) chain_q <= {chain_q[STAGES-2:0], sin_s};
    end

    assign ser_out = chain_q[STAGES-1];

    // R2
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_pulse |=> $stable(chain_q));

    // R3
    entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> chain_q[0] == $past(sin_s));

    // R4
    cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> ser_out == $past(chain_q[STAGES-2]));

endmodule

// File: rtl/led_sink_front.sv
module led_sink_front
    import led_front_pkg::*;
#(
    parameter int CHANNELS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_in,
    input  logic                shift_clk,
    input  logic                strobe,
    input  logic                enable_n,
    output logic                ser_out,
    output logic [CHANNELS-1:0] chan_on
);

    localparam logic [PIN_COUNT-1:0] PIN_RST = PIN_COUNT'(1) << PIN_ENN;

    logic [PIN_COUNT-1:0] pins_raw, pins_s;
    logic                 shift_pulse;
    logic [CHANNELS-1:0]  chain_q;
    logic [CHANNELS-1:0]  held_q;
    logic                 strobe_s, blank_s;

    assign pins_raw = {enable_n, strobe, shift_clk, ser_in};

    led_pin_sync #(
        .WIDTH   (PIN_COUNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pins_raw),
        .pin_sync  (pins_s)
    );

    assign strobe_s = pins_s[PIN_STROBE];
    assign blank_s  = pins_s[PIN_ENN];

    led_sclk_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (pins_s[PIN_SCLK]),
        .shift_pulse (shift_pulse)
    );

    led_shift_chain #(
        .STAGES (CHANNELS)
    ) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_pulse (shift_pulse),
        .sin_s       (pins_s[PIN_SIN]),
        .chain_q     (chain_q),
        .ser_out     (ser_out)
    );

    // Level-sensitive holding stage, sampled on the system clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        held_q <= '0;
        else if (strobe_s) held_q <= chain_q;
    end

    assign chan_on = blank_s ? '0 : held_q;

    // R5
    transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_s |=> held_q == $past(chain_q));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_s |=> $stable(held_q));

    // R7
    blank_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pins_raw[PIN_ENN]) && $past(blank_s) |-> chan_on == '0);

endmodule

// File: tb/led_sink_front_tb.sv
module led_sink_front_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0, shift_clk = 1'b0, strobe = 1'b0, enable_n = 1'b1;
    logic sout_a, sout_b;
    logic [NCH-1:0] chan_a, chan_b;

    int    n_chk = 0, n_fail = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    led_sink_front #(.CHANNELS(NCH), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk),
        .strobe(strobe), .enable_n(enable_n), .ser_out(sout_a), .chan_on(chan_a));

    led_sink_front #(.CHANNELS(NCH), .SYNC_STAGES(2)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .ser_in(sout_a), .shift_clk(shift_clk),
        .strobe(strobe), .enable_n(enable_n), .ser_out(sout_b), .chan_on(chan_b));

    // ---------------- behavioural reference model ----------------
    bit m_reg_a[$], m_reg_b[$];
    bit h_clk[$], h_lat[$], h_en[$], h_sa[$], h_sb[$];
    bit m_clk_s, m_lat_s, m_en_s, m_sa_s, m_sb_s, m_was_high;
    logic [NCH-1:0] m_hold_a, m_hold_b;

    function automatic logic [NCH-1:0] q2v(bit q[$]);
        logic [NCH-1:0] v;
        for (int k = 0; k < NCH; k++) v[k] = q[k];
        return v;
    endfunction

    task automatic model_reset();
        m_reg_a = {}; m_reg_b = {};
        for (int k = 0; k < NCH; k++) begin m_reg_a.push_back(1'b0); m_reg_b.push_back(1'b0); end
        h_clk = {1'b0}; h_lat = {1'b0}; h_en = {1'b1}; h_sa = {1'b0}; h_sb = {1'b0};
        m_clk_s = 0; m_lat_s = 0; m_en_s = 1; m_sa_s = 0; m_sb_s = 0; m_was_high = 0;
        m_hold_a = '0; m_hold_b = '0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit last_a;
            last_a = m_reg_a[NCH-1];
            if (m_lat_s) begin
                m_hold_a = q2v(m_reg_a);
                m_hold_b = q2v(m_reg_b);
            end
            if (!m_was_high && m_clk_s) begin
                m_reg_a.push_front(m_sa_s); void'(m_reg_a.pop_back());
                m_reg_b.push_front(m_sb_s); void'(m_reg_b.pop_back());
            end
            m_was_high = m_clk_s;
            h_clk.push_back(shift_clk); m_clk_s = h_clk.pop_front();
            h_lat.push_back(strobe);    m_lat_s = h_lat.pop_front();
            h_en.push_back(enable_n);   m_en_s  = h_en.pop_front();
            h_sa.push_back(ser_in);     m_sa_s  = h_sa.pop_front();
            h_sb.push_back(last_a);     m_sb_s  = h_sb.pop_front();
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check(cur_req, "model chan_a", {16'h0, chan_a}, {16'h0, (m_en_s ? 16'h0 : m_hold_a)});
            check(cur_req, "model chan_b", {16'h0, chan_b}, {16'h0, (m_en_s ? 16'h0 : m_hold_b)});
            check(cur_req, "model souts", {30'h0, sout_b, sout_a},
                  {30'h0, m_reg_b[NCH-1], m_reg_a[NCH-1]});
        end
    end

    // ---------------- stimulus ----------------
    task automatic shift_bit(bit b, int high_cycles);
        @(negedge clk) ser_in = b;
        repeat (3) @(negedge clk);
        shift_clk = 1'b1;
        repeat (high_cycles) @(negedge clk);
        shift_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic shift_word(logic [NCH-1:0] w);
        for (int i = NCH-1; i >= 0; i--) shift_bit(w[i], 4);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "reset chan_a", {16'h0, chan_a}, 32'h0);
        check("R1", "reset chan_b", {16'h0, chan_b}, 32'h0);
        check("R1", "reset souts", {30'h0, sout_b, sout_a}, 32'h0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk) enable_n = 1'b0; strobe = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", "after reset chan_a", {16'h0, chan_a}, 32'h0);

        // R3, R5: load both blocks while transparent
        cur_req = "R3";
        shift_word(16'h1F80);
        shift_word(16'hA5C3);
        check("R3", "loaded chan_a", {16'h0, chan_a}, 32'h0000_A5C3);
        check("R5", "loaded chan_b", {16'h0, chan_b}, 32'h0000_1F80);
        check("R4", "sout_a is stage 15", {31'h0, sout_a}, 32'h1);
        check("R4", "sout_b is stage 15", {31'h0, sout_b}, 32'h0);

        // R6: hold while strobe low
        cur_req = "R6";
        @(negedge clk) strobe = 1'b0;
        shift_word(16'h0F0F);
        check("R6", "held chan_a", {16'h0, chan_a}, 32'h0000_A5C3);
        check("R6", "held chan_b", {16'h0, chan_b}, 32'h0000_1F80);

        // R4: cascade hand-off visible after strobe
        cur_req = "R4";
        @(negedge clk) strobe = 1'b1;
        repeat (5) @(negedge clk);
        check("R4", "new chan_a", {16'h0, chan_a}, 32'h0000_0F0F);
        check("R4", "cascaded chan_b", {16'h0, chan_b}, 32'h0000_A5C3);

        // R7: blanking
        cur_req = "R7";
        @(negedge clk) enable_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R7", "blank chan_a", {16'h0, chan_a}, 32'h0);
        check("R7", "blank chan_b", {16'h0, chan_b}, 32'h0);

        // R8: enable latency of two edges
        cur_req = "R8";
        enable_n = 1'b0;
        @(negedge clk);
        check("R8", "one edge after enable", {16'h0, chan_a}, 32'h0);
        @(negedge clk);
        check("R8", "two edges after enable", {16'h0, chan_a}, 32'h0000_0F0F);

        // R2: long high shifts once; falling edge shifts nothing
        cur_req = "R2";
        @(negedge clk) ser_in = 1'b1;
        repeat (3) @(negedge clk);
        shift_clk = 1'b1;
        repeat (20) @(negedge clk);
        check("R2", "single shift on long high a", {16'h0, chan_a}, 32'h0000_1E1F);
        check("R2", "single shift on long high b", {16'h0, chan_b}, 32'h0000_4B86);
        shift_clk = 1'b0;
        repeat (8) @(negedge clk);
        check("R2", "falling edge no shift a", {16'h0, chan_a}, 32'h0000_1E1F);
        check("R2", "falling edge no shift b", {16'h0, chan_b}, 32'h0000_4B86);

        // R9: strobe and shift edge in the same cycle
        cur_req = "R9";
        strobe = 1'b0; ser_in = 1'b0;
        repeat (5) @(negedge clk);
        shift_clk = 1'b1; strobe = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", "pre-shift value in pulse cycle", {16'h0, chan_a}, 32'h0000_1E1F);
        @(negedge clk);
        check("R9", "post-shift value next cycle a", {16'h0, chan_a}, 32'h0000_3C3E);
        check("R9", "post-shift value next cycle b", {16'h0, chan_b}, 32'h0000_970C);
        shift_clk = 1'b0;
        repeat (6) @(negedge clk);

        // R1: reset clears everything again
        cur_req = "R1";
        cmp_on = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "re-reset chan_a", {16'h0, chan_a}, 32'h0);
        check("R1", "re-reset souts", {30'h0, sout_b, sout_a}, 32'h0);

        finish_run();
    end

endmodule